// File: doc/BRIEF.md
# Converter Calibration Sequencer with Offset and Gain Correction

This block runs the calibration modes of a sigma-delta converter and corrects every conversion result with stored per-channel coefficients. A command carries a 3-bit mode, a target channel, and the current gain and update-rate codes. During a calibration the block counts completion strobes from the modulator and filter. On the last strobe it stores the value presented on the data input as the offset or full-scale coefficient of the chosen channel, sets the ready indication and drops back to idle. Some gain and rate pairs cannot be used for an internal full-scale calibration. A request with such a pair is refused and raises an error flag.

In continuous mode, each strobe's raw code first has the channel's offset removed. The difference is then scaled by the channel's full-scale coefficient, and the result is clamped into the output code range. Two select outputs tell the analog front end whether to connect the internal zero or the internal full-scale input. System calibrations leave the pins as they are.

Top module: `adc_cal_seq`

## Requirements
- R1: Mode codes are 000 continuous, 100 internal zero-scale, 101 internal full-scale, 110 system zero-scale and 111 system full-scale. Codes 001 to 011 put the block into idle, where strobes produce no output. A command is taken when `cmd_valid` is high, and a new command replaces whatever is in progress.
- R2: A zero-scale calibration, internal or system, completes on the second strobe. The raw code present on that strobe becomes the channel's offset coefficient, and earlier strobes store nothing.
- R3: `sel_zero` is high only while an internal zero-scale calibration runs, and `sel_fs` is high only while an internal full-scale calibration runs. Both are low for system calibrations and when the block is not calibrating.
- R4: An internal full-scale calibration completes on the second strobe at gain code 0 (gain 1) and on the fourth strobe at any other gain code. A system full-scale calibration completes on the second strobe at every gain and rate. The raw code on the completing strobe becomes the full-scale coefficient.
- R5: An internal full-scale request is refused in two cases: gain code 7 (gain 128), or gain code above 2 with a rate code other than 13, 14 or 15. A refused request sets `cal_err`, leaves the block idle and changes no coefficient. A legal command clears `cal_err`.
- R6: A legal command clears `rdy_stat`. `busy` is high from the cycle after a calibration command until completion. At completion `busy` drops and `rdy_stat` rises. `rdy_n` is low exactly when `rdy_stat` is set and `cs_n` is low, so it stays high during a calibration.
- R7: The corrected value is ((raw − offset) × fullscale) / 2^(DW−1), taken with an arithmetic right shift. The offset is therefore subtracted before scaling. A full-scale coefficient of 2^(DW−1) is unity.
- R8: A negative corrected value gives all zeros, and a value above 2^DW−1 gives all ones.
- R9: Each channel has its own coefficients. After reset every offset is 0 and every full-scale coefficient is unity.
- R10: In continuous mode, a strobe updates `data_out` and pulses `data_valid` for one cycle at the next clock edge, and it sets `rdy_stat`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_mode | input | 3 | Mode code |
| cmd_chan | input | $clog2(NCH) | Target channel |
| gain_code | input | 3 | Gain as a power of two (0 = 1, 7 = 128) |
| rate_code | input | 4 | Update-rate code |
| cs_n | input | 1 | Chip select, active low |
| conv_done | input | 1 | Conversion-complete strobe |
| raw_data | input | DW | Raw conversion code |
| data_out | output | DW | Corrected result |
| data_valid | output | 1 | One-cycle pulse when a result is written |
| rdy_stat | output | 1 | Ready status bit |
| rdy_n | output | 1 | Ready line, active low |
| cal_err | output | 1 | Refused calibration request |
| busy | output | 1 | Calibration in progress |
| sel_zero | output | 1 | Connect the internal zero input |
| sel_fs | output | 1 | Connect the internal full-scale input |

## Verification
The bench builds the block with DW = 12 and NCH = 2. With 12-bit codes the unity coefficient is 2048, so clamping at 0 and 4095 can be reached with small operands, and the expected products can be worked out by hand. Two channels are enough to show that a calibration on one channel leaves the other channel's coefficients alone, including after a refused request.

// File: rtl/adc_cal_seq.sv
module adc_cal_seq #(
  parameter int DW  = 24,
  parameter int NCH = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid,
  input  logic [2:0]             cmd_mode,
  input  logic [$clog2(NCH)-1:0] cmd_chan,
  input  logic [2:0]             gain_code,
  input  logic [3:0]             rate_code,
  input  logic                   cs_n,
  input  logic                   conv_done,
  input  logic [DW-1:0]          raw_data,
  output logic [DW-1:0]          data_out,
  output logic                   data_valid,
  output logic                   rdy_stat,
  output logic                   rdy_n,
  output logic                   cal_err,
  output logic                   busy,
  output logic                   sel_zero,
  output logic                   sel_fs
);
  localparam int CHW = $clog2(NCH);
  localparam int PW  = 2*DW + 2;
  localparam logic [DW-1:0] UNITY = DW'(1) << (DW-1);
  localparam logic [2:0] MD_CONT = 3'b000, MD_IZS = 3'b100, MD_IFS = 3'b101,
                         MD_SZS = 3'b110, MD_SFS = 3'b111;

  typedef enum logic [1:0] {ST_IDLE, ST_CONT, ST_CAL} st_t;
  st_t st_q;

  logic [2:0]     kind_q, cnt_q, need_q;
  logic [CHW-1:0] chan_q;
  logic [DW-1:0]  off_q [NCH];
  logic [DW-1:0]  fs_q  [NCH];

  wire bad_cmd = (cmd_mode == MD_IFS) &&
                 ((gain_code == 3'd7) || ((gain_code > 3'd2) && (rate_code < 4'd13)));

  logic signed [DW:0]   diff;
  logic signed [PW-1:0] scaled;
  logic        [DW-1:0] corr;

  always_comb begin
    diff   = $signed({1'b0, raw_data}) - $signed({1'b0, off_q[chan_q]});
    scaled = (PW'(diff) * PW'($signed({1'b0, fs_q[chan_q]}))) >>> (DW-1);
    if (scaled[PW-1])               corr = '0;
    else if (|scaled[PW-2:DW])      corr = '1;
    else                            corr = scaled[DW-1:0];
  end

  assign busy     = (st_q == ST_CAL);
  assign sel_zero = busy && (kind_q == MD_IZS);
  assign sel_fs   = busy && (kind_q == MD_IFS);
  assign rdy_n    = ~(rdy_stat & ~cs_n);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      kind_q     <= MD_CONT;
      cnt_q      <= '0;
      need_q     <= 3'd2;
      chan_q     <= '0;
      data_out   <= '0;
      data_valid <= 1'b0;
      rdy_stat   <= 1'b0;
      cal_err    <= 1'b0;
      for (int i = 0; i < NCH; i++) begin
        off_q[i] <= '0;
        fs_q[i]  <= UNITY;
      end
    end else begin
      data_valid <= 1'b0;
      if (cmd_valid) begin
        if (bad_cmd) begin
          cal_err <= 1'b1;
          st_q    <= ST_IDLE;
        end else begin
          cal_err  <= 1'b0;
          rdy_stat <= 1'b0;
          chan_q   <= cmd_chan;
          kind_q   <= cmd_mode;
          cnt_q    <= '0;
          need_q   <= (cmd_mode == MD_IFS && gain_code != 3'd0) ? 3'd4 : 3'd2;
          case (cmd_mode)
            MD_CONT:                        st_q <= ST_CONT;
            MD_IZS, MD_IFS, MD_SZS, MD_SFS: st_q <= ST_CAL;
            default:                        st_q <= ST_IDLE;
          endcase
        end
      end else if (conv_done) begin
        if (st_q == ST_CONT) begin
          data_out   <= corr;
          data_valid <= 1'b1;
          rdy_stat   <= 1'b1;
        end else if (st_q == ST_CAL) begin
          if (cnt_q + 3'd1 == need_q) begin
            if (kind_q[0]) fs_q[chan_q]  <= raw_data;
            else           off_q[chan_q] <= raw_data;
            st_q     <= ST_IDLE;
            rdy_stat <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 3'd1;
          end
        end
      end
    end
  end

  AST_RDY_HIGH_CAL: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> rdy_n);  // R6
  AST_CAL_DONE_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !$past(cmd_valid)) |-> rdy_stat);  // R6
  AST_BAD_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && bad_cmd) |=> (!busy && cal_err));  // R5
  AST_SEL_IN_CAL: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_zero || sel_fs) |-> (busy && !(sel_zero && sel_fs)));  // R3
  AST_VALID_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> ($past(conv_done) && !busy));  // R10
endmodule

// File: tb/adc_cal_seq_bench.sv
module adc_cal_seq_bench;
  localparam int DW = 12;
  localparam int NCH = 2;
  localparam int MAXC = (1 << DW) - 1;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cs_n = 0, conv_done = 0;
  logic [2:0] cmd_mode = 0, gain_code = 0;
  logic [0:0] cmd_chan = 0;
  logic [3:0] rate_code = 0;
  logic [DW-1:0] raw_data = 0, data_out;
  logic data_valid, rdy_stat, rdy_n, cal_err, busy, sel_zero, sel_fs;

  int checks = 0, errors = 0;

  adc_cal_seq #(.DW(DW), .NCH(NCH)) u_adc_cal_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_mode(cmd_mode),
    .cmd_chan(cmd_chan), .gain_code(gain_code), .rate_code(rate_code),
    .cs_n(cs_n), .conv_done(conv_done), .raw_data(raw_data),
    .data_out(data_out), .data_valid(data_valid), .rdy_stat(rdy_stat),
    .rdy_n(rdy_n), .cal_err(cal_err), .busy(busy), .sel_zero(sel_zero),
    .sel_fs(sel_fs));

  always #4 clk = ~clk;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic longint model(input longint raw, input longint off, input longint fs);
    longint v = ((raw - off) * fs) >>> (DW - 1);
    if (v < 0) return 0;
    if (v > MAXC) return MAXC;
    return v;
  endfunction

  task automatic cmd(input logic [2:0] m, input logic ch, input logic [2:0] g, input logic [3:0] r);
    @(negedge clk);
    cmd_valid = 1; cmd_mode = m; cmd_chan = ch; gain_code = g; rate_code = r;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic strobe(input int raw);
    @(negedge clk);
    conv_done = 1; raw_data = DW'(raw);
    @(negedge clk);
    conv_done = 0;
  endtask

  task automatic convert(input logic ch, input int raw, input longint exp, input string tag);
    cmd(3'b000, ch, 3'd0, 4'd0);
    strobe(raw);
    chk({tag, " data"}, data_out, exp);
    chk("R10 valid pulse", data_valid, 1);
    chk("R10 rdy_stat", rdy_stat, 1);
    @(negedge clk);
    chk("R10 valid one cycle", data_valid, 0);
  endtask

  task automatic t_reset;
    chk("R9 reset data", data_out, 0);
    chk("R6 reset rdy_stat", rdy_stat, 0);
    chk("R6 reset rdy_n", rdy_n, 1);
    chk("R5 reset err", cal_err, 0);
    chk("R6 reset busy", busy, 0);
    convert(0, 1000, 1000, "R9 unity default ch0");
    convert(1, 4095, 4095, "R9 unity default ch1");
  endtask

  task automatic t_zero_cal;
    cmd(3'b100, 0, 3'd0, 4'd0);
    chk("R6 busy after start", busy, 1);
    chk("R6 rdy_n high in cal", rdy_n, 1);
    chk("R3 sel_zero internal", sel_zero, 1);
    chk("R3 sel_fs off", sel_fs, 0);
    strobe(50);
    chk("R2 not done after one", busy, 1);
    strobe(100);
    chk("R2 done after two", busy, 0);
    chk("R6 rdy_stat set", rdy_stat, 1);
    chk("R6 rdy_n low with cs", rdy_n, 0);
    cs_n = 1; #1;
    chk("R6 rdy_n high without cs", rdy_n, 1);
    cs_n = 0;
    chk("R3 sel_zero after", sel_zero, 0);
    convert(0, 1000, 900, "R2 offset captured");
  endtask

  task automatic t_sys_fs;
    cmd(3'b111, 0, 3'd5, 4'd0);
    chk("R5 sys fs legal err", cal_err, 0);
    chk("R3 sys fs no sel", sel_fs, 0);
    chk("R6 rdy cleared", rdy_stat, 0);
    strobe(10);
    chk("R4 sys fs busy", busy, 1);
    strobe(3072);
    chk("R4 sys fs two", busy, 0);
    convert(0, 1100, model(1100, 100, 3072), "R7 offset then scale");
  endtask

  task automatic t_int_fs;
    cmd(3'b101, 1, 3'd0, 4'd0);
    chk("R3 sel_fs internal", sel_fs, 1);
    strobe(7);
    strobe(1024);
    chk("R4 ifs gain1 two", busy, 0);
    convert(1, 2000, 1000, "R4 ifs gain1 coef");
    cmd(3'b101, 1, 3'd3, 4'd14);
    chk("R5 slow rate legal", cal_err, 0);
    strobe(1); strobe(2);
    chk("R4 ifs not done at two", busy, 1);
    strobe(3);
    chk("R4 ifs not done at three", busy, 1);
    strobe(4000);
    chk("R4 ifs done at four", busy, 0);
    convert(1, 1024, 2000, "R4 ifs gain8 coef");
    convert(0, 1100, 1500, "R9 ch0 untouched");
  endtask

  task automatic t_illegal;
    cmd(3'b101, 1, 3'd7, 4'd15);
    chk("R5 gain128 err", cal_err, 1);
    chk("R5 gain128 idle", busy, 0);
    strobe(9);
    convert(1, 1024, 2000, "R5 coef kept");
    chk("R5 err cleared by legal", cal_err, 0);
    cmd(3'b101, 1, 3'd4, 4'd3);
    chk("R5 fast rate err", cal_err, 1);
    cmd(3'b111, 1, 3'd7, 4'd0);
    chk("R5 sys fs gain128 ok", busy, 1);
    strobe(0); strobe(2048);
    convert(1, 777, 777, "R4 sys fs gain128 unity");
  endtask

  task automatic t_sat_idle;
    convert(0, 50, 0, "R8 clamp low");
    convert(0, 3000, MAXC, "R8 clamp high");
    cmd(3'b010, 0, 3'd0, 4'd0);
    strobe(500);
    chk("R1 idle no output", data_valid, 0);
    chk("R1 idle data hold", data_out, MAXC);
    cmd(3'b110, 0, 3'd0, 4'd0);
    chk("R3 sys zero no sel", sel_zero, 0);
    strobe(1);
    cmd(3'b000, 0, 3'd0, 4'd0);
    chk("R1 override ends cal", busy, 0);
    strobe(1100);
    chk("R1 offset unchanged", data_out, 1500);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_zero_cal;
    t_sys_fs;
    t_int_fs;
    t_illegal;
    t_sat_idle;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule